// File: doc/BRIEF.md
# Masked data-value breakpoint comparator

This block sits beside the address comparator of one breakpoint channel and decides whether a completed data access should raise a break request. On every access it receives the outcome of the address comparison, the data on the 32-bit bus, the access size, address bit 0 and an access strobe. When data matching is switched off, an address hit alone produces a break. When data matching is switched on, a break also needs the bus data to agree with a programmed value on every bit that the programmed mask does not exclude.

The compare width follows the access size. Longword accesses compare all 32 bits. Word accesses compare only the low halfword, and the upper halfword of the bus, the value register and the mask register plays no part. Byte accesses compare the byte lane that address bit 0 selects. Software is expected to replicate the byte pattern in both low bytes of the value and mask registers, so that a byte on either lane can hit. The channel's size code must permit data breaks, and otherwise the request is suppressed.

Software loads the value, mask and control registers through three plain write strobes. The result is a registered pulse, one clock wide, handed on to the trap logic. A two-state machine produces it. ST_IDLE moves to ST_PULSE on a qualifying access (transition QUALIFY). ST_PULSE stays in ST_PULSE when another qualifying access completes (transition REFIRE) and returns to ST_IDLE otherwise (transition EXPIRE). ST_IDLE stays in ST_IDLE when no access qualifies (transition HOLD).

Top module: `dbrk_data_cmp`

## Requirements
- R1: While the data-match enable bit is 0, the cycle after any access with `bus_strobe`=1 and `bus_addr_hit`=1 has `brk_req`=1, whatever the data, the access size or the size code.
- R2: `brk_req` is 1 only in the cycle after an access with `bus_strobe`=1 and `bus_addr_hit`=1. An address miss or an idle bus never breaks, even when the data matches.
- R3: With the enable bit at 1, size code 00 and a longword access (`bus_size`=10), a break occurs exactly when `(bus_data ^ value) & ~mask` is zero over all 32 bits. A mask bit of 1 means the bit is not compared.
- R4: For a word access (`bus_size`=01), only bits 15..0 are compared. Bits 31..16 of the bus, the value register and the mask register have no effect.
- R5: For a byte access (`bus_size`=00), `bus_a0`=0 compares `bus_data[7:0]` against value and mask bits 7..0. `bus_a0`=1 compares `bus_data[15:8]` against bits 15..8. All other data bits are ignored.
- R6: Size code 01 lets only byte accesses qualify when data matching is enabled. Word and longword accesses then never break.
- R7: Size codes 10 and 11 with data matching enabled suppress every break.
- R8: Each qualifying access gives exactly one cycle of `brk_req`. Two qualifying accesses in consecutive cycles give two consecutive high cycles, followed by a low cycle once accesses stop.
- R9: Reset clears `brk_req`, the value and mask registers, the enable bit and the size code. After reset, an address hit therefore breaks on the address condition alone.
- R10: Bus size code 11 is reserved and never satisfies the data condition when data matching is enabled.
- R11: The control write (`cfg_ctrl_we`) loads the enable bit from `cfg_ctrl_en` and the size code from `cfg_ctrl_size`. `cfg_value_we` and `cfg_mask_we` load `cfg_wdata` into the value and mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl_we | input | 1 | Load the enable bit and the size code |
| cfg_ctrl_en | input | 1 | Data-match enable value to load |
| cfg_ctrl_size | input | 2 | Size code to load (00 any size, 01 byte only, 1x not allowed) |
| cfg_value_we | input | 1 | Load the value register from cfg_wdata |
| cfg_mask_we | input | 1 | Load the mask register from cfg_wdata |
| cfg_wdata | input | 32 | Write data for the value and mask registers |
| bus_strobe | input | 1 | A data access completes this cycle |
| bus_addr_hit | input | 1 | Address condition met by this access |
| bus_size | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 reserved |
| bus_a0 | input | 1 | Address bit 0, selects the byte lane |
| bus_data | input | 32 | Data carried by the access |
| brk_req | output | 1 | Break request pulse, one clock after the access |

## Verification
The stimulus table sweeps longword data that matches exactly, misses by one bit, and matches only because the mask hides the differing bits. This shows whether the mask polarity and the full-width compare are right. Word accesses are given a value register and bus data whose upper halves differ, which exposes any leak of bits 31..16 into the decision. Byte accesses on both lanes are given data in which only the unselected lane matches, which separates correct lane steering from a compare on both lanes or on the wrong one. Size codes 01, 10 and 11, the reserved bus size, and address misses with matching data each confirm a suppression path. Directed runs check the reset state, the pulse width, and back-to-back refiring.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF_LANES = LANES / 2;

    typedef enum logic [1:0] {
        BUS_BYTE = 2'b00,
        BUS_WORD = 2'b01,
        BUS_LONG = 2'b10,
        BUS_RSVD = 2'b11
    } bus_size_e;

    typedef enum logic [1:0] {
        CH_ANY   = 2'b00,
        CH_BYTE  = 2'b01,
        CH_BAD_A = 2'b10,
        CH_BAD_B = 2'b11
    } ch_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } brk_state_e;

endpackage

// File: rtl/dbrk_cfg_regs.sv
module dbrk_cfg_regs
    import dbrk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         ctrl_en,
    input  logic [1:0]   ctrl_size,
    input  logic         value_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    output logic         en_q,
    output ch_size_e     size_q,
    output logic [W-1:0] value_q,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            size_q <= CH_ANY;
        end else if (ctrl_we) begin
            en_q   <= ctrl_en;
            size_q <= ch_size_e'(ctrl_size);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (value_we) begin
            value_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

endmodule

// File: rtl/dbrk_lane_cmp.sv
module dbrk_lane_cmp #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] data,
    input  logic [LW-1:0] value,
    input  logic [LW-1:0] mask,
    output logic          equal
);

    logic [LW-1:0] diff;

    always_comb begin
        diff  = (data ^ value) & ~mask;
        equal = (diff == '0);
    end

endmodule

// File: rtl/dbrk_data_match.sv
module dbrk_data_match
    import dbrk_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int LW = LANE_W
) (
    input  logic [W-1:0] bus_data,
    input  bus_size_e    bus_size,
    input  logic         bus_a0,
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    input  ch_size_e     ch_size,
    output logic         data_ok,
    output logic         size_ok
);

    localparam int NL = W / LW;
    localparam int NH = NL / 2;

    logic [NL-1:0] lane_eq;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        dbrk_lane_cmp #(.LW(LW)) u_lane (
            .data  (bus_data[i*LW +: LW]),
            .value (value[i*LW +: LW]),
            .mask  (mask[i*LW +: LW]),
            .equal (lane_eq[i])
        );
    end

    always_comb begin
        unique case (bus_size)
            BUS_BYTE: data_ok = bus_a0 ? lane_eq[1] : lane_eq[0];
            BUS_WORD: data_ok = &lane_eq[NH-1:0];
            BUS_LONG: data_ok = &lane_eq;
            BUS_RSVD: data_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ch_size)
            CH_ANY:   size_ok = (bus_size != BUS_RSVD);
            CH_BYTE:  size_ok = (bus_size == BUS_BYTE);
            CH_BAD_A: size_ok = 1'b0;
            CH_BAD_B: size_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbrk_data_cmp.sv
module dbrk_data_cmp
    import dbrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ctrl_we,
    input  logic              cfg_ctrl_en,
    input  logic [1:0]        cfg_ctrl_size,
    input  logic              cfg_value_we,
    input  logic              cfg_mask_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              bus_strobe,
    input  logic              bus_addr_hit,
    input  logic [1:0]        bus_size,
    input  logic              bus_a0,
    input  logic [DATA_W-1:0] bus_data,
    output logic              brk_req
);

    logic              data_en_q;
    ch_size_e          size_q;
    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] mask_q;
    logic              data_ok;
    logic              size_ok;
    logic              qualify;

    brk_state_e state_q;
    brk_state_e state_d;

    dbrk_cfg_regs #(.W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (cfg_ctrl_we),
        .ctrl_en   (cfg_ctrl_en),
        .ctrl_size (cfg_ctrl_size),
        .value_we  (cfg_value_we),
        .mask_we   (cfg_mask_we),
        .wdata     (cfg_wdata),
        .en_q      (data_en_q),
        .size_q    (size_q),
        .value_q   (value_q),
        .mask_q    (mask_q)
    );

    dbrk_data_match #(.W(DATA_W), .LW(LANE_W)) u_match (
        .bus_data (bus_data),
        .bus_size (bus_size_e'(bus_size)),
        .bus_a0   (bus_a0),
        .value    (value_q),
        .mask     (mask_q),
        .ch_size  (size_q),
        .data_ok  (data_ok),
        .size_ok  (size_ok)
    );

    always_comb begin
        qualify = bus_strobe && bus_addr_hit && (!data_en_q || (size_ok && data_ok));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = qualify ? ST_PULSE : ST_IDLE;   // QUALIFY / HOLD
            ST_PULSE: state_d = qualify ? ST_PULSE : ST_IDLE;   // REFIRE / EXPIRE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  brk_req = 1'b0;
            ST_PULSE: brk_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/dbrk_data_cmp_chk.sv
module dbrk_data_cmp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_strobe,
    input logic        bus_addr_hit,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_data,
    input logic        en,
    input logic [1:0]  csize,
    input logic [31:0] value,
    input logic [31:0] mask,
    input logic        brk_req
);

    assert_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_strobe && bus_addr_hit));

    assert_addr_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr_hit && !en) |=> brk_req);

    assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && en && csize[1]) |=> !brk_req);

    assert_rsvd_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && en && bus_size == 2'b11) |=> !brk_req);

    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !(bus_strobe && bus_addr_hit)) |=> !brk_req);

    assert_long_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr_hit && en && csize == 2'b00 && bus_size == 2'b10
         && (((bus_data ^ value) & ~mask) == 32'h0)) |=> brk_req);

endmodule

bind dbrk_data_cmp dbrk_data_cmp_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_strobe   (bus_strobe),
    .bus_addr_hit (bus_addr_hit),
    .bus_size     (bus_size),
    .bus_data     (bus_data),
    .en           (data_en_q),
    .csize        (size_q),
    .value        (value_q),
    .mask         (mask_q),
    .brk_req      (brk_req)
);

// File: tb/dbrk_data_cmp_tb.sv
module dbrk_data_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ctrl_we = 1'b0;
    logic        cfg_ctrl_en = 1'b0;
    logic [1:0]  cfg_ctrl_size = 2'b00;
    logic        cfg_value_we = 1'b0;
    logic        cfg_mask_we = 1'b0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        bus_strobe = 1'b0;
    logic        bus_addr_hit = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic        bus_a0 = 1'b0;
    logic [31:0] bus_data = 32'h0;
    logic        brk_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbrk_data_cmp u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ctrl_we(cfg_ctrl_we), .cfg_ctrl_en(cfg_ctrl_en), .cfg_ctrl_size(cfg_ctrl_size),
        .cfg_value_we(cfg_value_we), .cfg_mask_we(cfg_mask_we), .cfg_wdata(cfg_wdata),
        .bus_strobe(bus_strobe), .bus_addr_hit(bus_addr_hit), .bus_size(bus_size),
        .bus_a0(bus_a0), .bus_data(bus_data), .brk_req(brk_req)
    );

    typedef struct packed {
        logic        en;
        logic [1:0]  cs;
        logic [31:0] v;
        logic [31:0] m;
        logic        hit;
        logic [1:0]  bs;
        logic        a0;
        logic [31:0] d;
        logic        exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'b10, 1'b0, 32'hDEAD_BEEF, 1'b1},
        '{1'b0, 2'b00, 32'h0000_0000, 32'h0000_0000, 1'b0, 2'b10, 1'b0, 32'hDEAD_BEEF, 1'b0},
        '{1'b1, 2'b00, 32'h1234_5678, 32'h0000_0000, 1'b1, 2'b10, 1'b0, 32'h1234_5678, 1'b1},
        '{1'b1, 2'b00, 32'h1234_5678, 32'h0000_0000, 1'b1, 2'b10, 1'b0, 32'h1234_5679, 1'b0},
        '{1'b1, 2'b00, 32'h1234_5678, 32'h0000_000F, 1'b1, 2'b10, 1'b0, 32'h1234_567A, 1'b1},
        '{1'b1, 2'b00, 32'h1234_5678, 32'h0000_0000, 1'b0, 2'b10, 1'b0, 32'h1234_5678, 1'b0},
        '{1'b1, 2'b00, 32'hFFFF_1234, 32'h0000_0000, 1'b1, 2'b01, 1'b0, 32'h0000_1234, 1'b1},
        '{1'b1, 2'b00, 32'hFFFF_1234, 32'h0000_0000, 1'b1, 2'b01, 1'b0, 32'h0000_1235, 1'b0},
        '{1'b1, 2'b00, 32'h0000_AAAA, 32'h0000_0000, 1'b1, 2'b00, 1'b0, 32'h1234_56AA, 1'b1},
        '{1'b1, 2'b00, 32'h0000_AAAA, 32'h0000_0000, 1'b1, 2'b00, 1'b1, 32'h1234_AA00, 1'b1},
        '{1'b1, 2'b00, 32'h0000_AAAA, 32'h0000_0000, 1'b1, 2'b00, 1'b1, 32'h1234_00AA, 1'b0},
        '{1'b1, 2'b01, 32'h0000_AAAA, 32'h0000_0000, 1'b1, 2'b00, 1'b0, 32'h0000_00AA, 1'b1},
        '{1'b1, 2'b01, 32'h0000_AAAA, 32'h0000_0000, 1'b1, 2'b01, 1'b0, 32'h0000_AAAA, 1'b0},
        '{1'b1, 2'b10, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'b10, 1'b0, 32'h0000_0000, 1'b0},
        '{1'b1, 2'b11, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'b10, 1'b0, 32'h0000_0000, 1'b0},
        '{1'b1, 2'b00, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'b11, 1'b0, 32'h0000_0000, 1'b0},
        '{1'b1, 2'b00, 32'h0000_A5A5, 32'h0000_F0F0, 1'b1, 2'b00, 1'b0, 32'h0000_00F5, 1'b1}
    };

    localparam string TAGS [NV] = '{
        "R1", "R2", "R3", "R3", "R3", "R2", "R4", "R4", "R5",
        "R5", "R5", "R6", "R6", "R7", "R7", "R10", "R11"
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s brk_req actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [1:0] cs,
                             input logic [31:0] v, input logic [31:0] m);
        @(negedge clk);
        cfg_ctrl_we = 1'b1; cfg_ctrl_en = en; cfg_ctrl_size = cs;
        cfg_value_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_ctrl_we = 1'b0; cfg_value_we = 1'b0;
        cfg_mask_we = 1'b1; cfg_wdata = m;
        @(negedge clk);
        cfg_mask_we = 1'b0;
    endtask

    task automatic drive_access(input logic hit, input logic [1:0] bs,
                                input logic a0, input logic [31:0] d);
        bus_strobe = 1'b1; bus_addr_hit = hit; bus_size = bs; bus_a0 = a0; bus_data = d;
    endtask

    task automatic idle_bus();
        bus_strobe = 1'b0; bus_addr_hit = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", brk_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", brk_req, 1'b0);

        // R9: registers cleared, so an address hit breaks without a data compare
        drive_access(1'b1, 2'b10, 1'b0, 32'hCAFE_F00D);
        @(negedge clk);
        idle_bus();
        check("R9", brk_req, 1'b1);
        @(negedge clk);
        check("R8", brk_req, 1'b0);

        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i].en, VECS[i].cs, VECS[i].v, VECS[i].m);
            drive_access(VECS[i].hit, VECS[i].bs, VECS[i].a0, VECS[i].d);
            @(negedge clk);
            idle_bus();
            check(TAGS[i], brk_req, VECS[i].exp);
            @(negedge clk);
            check("R8", brk_req, 1'b0);
        end

        // R8: two qualifying accesses back to back
        write_cfg(1'b1, 2'b00, 32'h5555_0000, 32'h0000_FFFF);
        drive_access(1'b1, 2'b10, 1'b0, 32'h5555_1234);
        @(negedge clk);
        check("R8", brk_req, 1'b1);
        drive_access(1'b1, 2'b10, 1'b0, 32'h5555_9999);
        @(negedge clk);
        idle_bus();
        check("R8", brk_req, 1'b1);
        @(negedge clk);
        check("R8", brk_req, 1'b0);

        // R2: strobe low with hit and matching data
        bus_strobe = 1'b0; bus_addr_hit = 1'b1; bus_size = 2'b10; bus_data = 32'h5555_0000;
        @(negedge clk);
        bus_addr_hit = 1'b0;
        check("R2", brk_req, 1'b0);

        // R5: lane 0 ignores upper bits even when lane 1 mismatches
        write_cfg(1'b1, 2'b01, 32'h0000_3C3C, 32'h0000_0000);
        drive_access(1'b1, 2'b00, 1'b0, 32'hFFFF_003C);
        @(negedge clk);
        idle_bus();
        check("R5", brk_req, 1'b1);
        @(negedge clk);
        check("R8", brk_req, 1'b0);

        // R6: longword access under byte-only size code
        drive_access(1'b1, 2'b10, 1'b0, 32'h0000_3C3C);
        @(negedge clk);
        idle_bus();
        check("R6", brk_req, 1'b0);

        // R1: disabling data match restores the address-only decision
        write_cfg(1'b0, 2'b11, 32'h0000_0000, 32'h0000_0000);
        drive_access(1'b1, 2'b11, 1'b1, 32'h1111_2222);
        @(negedge clk);
        idle_bus();
        check("R1", brk_req, 1'b1);
        @(negedge clk);
        check("R8", brk_req, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule